// File: doc/BRIEF.md
# EEPROM image checksum loader

This block sits on top of a word-level access port of a small serial EEPROM master (64 words of 16 bits by default). Out of reset, or whenever a start pulse arrives while it is idle, it fetches the whole image one word at a time. Each word goes into a local register array and is added to a running 16-bit sum. At the end it decides whether the image can be trusted. Two conditions must both hold. The wrapped sum of every word must equal a fixed non-zero target. A signature field in one chosen word, after masking, must equal an expected pattern.

On an update request the block fetches every word except the last, computes the balancing word (target minus partial sum, modulo 2^16) and writes it to the last address. It then runs a full validation pass by itself, so the valid flag reflects the repaired image. Consumers read captured words through a combinational lookup port. A busy output marks every pass.

Top module: `ee_image_loader`

## Requirements
- R1: While reset is asserted, busy, imageValid, memRdReq and memWrReq are all low. After reset releases, a validation pass starts on the first clock with no request from outside, and busy goes high.
- R2: Only one read is in flight at a time. memRdReq is a one-cycle pulse, and memRdAddr holds its value until memRdDone. No new request is issued before the done of the previous one. In a validation pass the addresses run 0, 1, ..., WORDS-1.
- R3: The checksum passes only when the sum of all WORDS captured words, modulo 2^16, equals SUM_TARGET (default 0xBABA). Any other sum gives imageValid = 0.
- R4: The signature passes only when word SIG_INDEX (default 10) ANDed with SIG_MASK (default 0xC000) equals SIG_VALUE (default 0x4000). Bits outside the mask have no effect.
- R5: imageValid is 1 only when both R3 and R4 pass. It is 0 for the whole time busy is 1, and it only rises at the end of a validation pass.
- R6: A startPulse seen while idle begins a new validation pass. A startPulse or updateReq that arrives while busy is ignored: no extra reads and no write result from it.
- R7: An updateReq seen while idle reads only words 0 to WORDS-2 (WORDS-1 reads). It then issues exactly one one-cycle memWrReq with memWrAddr = WORDS-1 and memWrData = SUM_TARGET minus that partial sum, modulo 2^16, and waits for memWrDone.
- R8: After memWrDone of an update, a full validation pass of WORDS reads follows automatically. Its imageValid is 1 when the signature matches and 0 when it does not.
- R9: lookData shows, combinationally, the captured word at lookAddr. After an update, the last word shows the value that was written.
- R10: If startPulse and updateReq are both high in the same idle cycle, the update is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Request a validation pass |
| updateReq | input | 1 | Request checksum repair followed by validation |
| memRdReq | output | 1 | One-cycle word read request to the EEPROM master |
| memRdAddr | output | ADDR_W | Word address of the read |
| memRdDone | input | 1 | Read completed; memRdData is valid in this cycle |
| memRdData | input | DATA_W | Word returned by the master |
| memWrReq | output | 1 | One-cycle word write request |
| memWrAddr | output | ADDR_W | Word address of the write (always the last word) |
| memWrData | output | DATA_W | Balancing word to write |
| memWrDone | input | 1 | Write completed |
| busy | output | 1 | A pass is in progress |
| imageValid | output | 1 | Last completed pass found checksum and signature good |
| lookAddr | input | ADDR_W | Lookup address into captured words |
| lookData | output | DATA_W | Captured word at lookAddr |

## Verification
The main function is tried with several images. A balanced image with a good signature must be accepted. The same image with one word changed isolates the sum test. A balanced image whose masked signature is wrong isolates the signature test. A balanced image whose signature word has noise outside the mask shows that the mask is applied. Update runs start from images whose last word is wrong, with a good signature and with a bad one. These show that the written word is computed from the first WORDS-1 words only, and that the automatic re-validation still applies the signature rule. Requests that arrive mid-pass, and start and update raised together, exercise the rules for ignoring a request and for priority.

// File: rtl/ee_loader_pkg.sv
package ee_loader_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ISSUE,
    S_RD_WAIT,
    S_JUDGE,
    S_WR_ISSUE,
    S_WR_WAIT
  } loadState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAcc;    // zero index and running sum
    logic clrValid;  // drop image-valid at pass start
    logic capture;   // store returned word, accumulate, step index
    logic latchBal;  // compute balancing word from partial sum
    logic storeBal;  // copy balancing word into last slot
    logic judge;     // evaluate checksum and signature
  } dpStrobe_t;

endpackage

// File: rtl/ee_loader_ctrl.sv
module ee_loader_ctrl
  import ee_loader_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      updateReq,
  input  logic      memRdDone,
  input  logic      memWrDone,
  input  logic      atLast,
  input  logic      atPenult,
  output dpStrobe_t strobe,
  output logic      memRdReq,
  output logic      memWrReq,
  output logic      busy
);

  loadState_t state;
  logic       updMode;
  logic       bootPending;
  logic       goAny;
  logic       passEnd;

  assign goAny   = updateReq | startPulse | bootPending;
  assign passEnd = updMode ? atPenult : atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      updMode     <= 1'b0;
      bootPending <= 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          if (goAny) begin
            state       <= S_RD_ISSUE;
            updMode     <= updateReq;   // update wins over start
            bootPending <= 1'b0;
          end
        end
        S_RD_ISSUE: state <= S_RD_WAIT;
        S_RD_WAIT: begin
          if (memRdDone) state <= passEnd ? S_JUDGE : S_RD_ISSUE;
        end
        S_JUDGE: state <= updMode ? S_WR_ISSUE : S_IDLE;
        S_WR_ISSUE: state <= S_WR_WAIT;
        S_WR_WAIT: begin
          if (memWrDone) begin
            state   <= S_RD_ISSUE;
            updMode <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.clrAcc   = ((state == S_IDLE) && goAny) ||
                      ((state == S_WR_WAIT) && memWrDone);
    strobe.clrValid = (state == S_IDLE) && goAny;
    strobe.capture  = (state == S_RD_WAIT) && memRdDone;
    strobe.latchBal = (state == S_JUDGE) && updMode;
    strobe.judge    = (state == S_JUDGE) && !updMode;
    strobe.storeBal = (state == S_WR_WAIT) && memWrDone;
  end

  assign memRdReq = (state == S_RD_ISSUE);
  assign memWrReq = (state == S_WR_ISSUE);
  assign busy     = (state != S_IDLE);

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |=> !memRdReq);

  // R7
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |=> !memWrReq);

  // R6
  busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memWrDone && !(memRdDone && passEnd) && state != S_JUDGE) |=> busy);

endmodule

// File: rtl/ee_loader_dp.sv
module ee_loader_dp
  import ee_loader_pkg::*;
#(
  parameter int                 WORDS      = 64,
  parameter int                 DATA_W     = 16,
  parameter int                 ADDR_W     = $clog2(WORDS),
  parameter logic [DATA_W-1:0]  SUM_TARGET = 16'hBABA,
  parameter logic [DATA_W-1:0]  SIG_MASK   = 16'hC000,
  parameter logic [DATA_W-1:0]  SIG_VALUE  = 16'h4000,
  parameter int                 SIG_INDEX  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [ADDR_W-1:0] lookAddr,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              atLast,
  output logic              atPenult,
  output logic              imageValid,
  output logic [DATA_W-1:0] lookData
);

  localparam logic [ADDR_W-1:0] LAST_IDX   = ADDR_W'(WORDS - 1);
  localparam logic [ADDR_W-1:0] PENULT_IDX = ADDR_W'(WORDS - 2);

  logic [DATA_W-1:0] words [WORDS];
  logic [ADDR_W-1:0] idx;
  logic [DATA_W-1:0] sumAcc;
  logic [DATA_W-1:0] balance;
  logic              sumGood;
  logic              sigGood;

  // captured image
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) words[i] <= '0;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (strobe.capture && idx == ADDR_W'(i)) words[i] <= memRdData;
        else if (strobe.storeBal && i == WORDS - 1) words[i] <= balance;
      end
    end
  end

  // index and running sum
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx    <= '0;
      sumAcc <= '0;
    end else if (strobe.clrAcc) begin
      idx    <= '0;
      sumAcc <= '0;
    end else if (strobe.capture) begin
      sumAcc <= sumAcc + memRdData;
      if (idx != LAST_IDX) idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                balance <= '0;
    else if (strobe.latchBal) balance <= SUM_TARGET - sumAcc;
  end

  assign sumGood = (sumAcc == SUM_TARGET);
  assign sigGood = ((words[SIG_INDEX] & SIG_MASK) == SIG_VALUE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                imageValid <= 1'b0;
    else if (strobe.clrValid) imageValid <= 1'b0;
    else if (strobe.judge)    imageValid <= sumGood && sigGood;
  end

  assign memRdAddr = idx;
  assign memWrAddr = LAST_IDX;
  assign memWrData = balance;
  assign atLast    = (idx == LAST_IDX);
  assign atPenult  = (idx == PENULT_IDX);
  assign lookData  = words[lookAddr];

  // R5
  valid_rise_judge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(imageValid) |-> $past(strobe.judge));

  // R9
  bal_stored_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeBal |=> (words[WORDS-1] == $past(balance)));

endmodule

// File: rtl/ee_image_loader.sv
module ee_image_loader
  import ee_loader_pkg::*;
#(
  parameter int                 WORDS      = 64,
  parameter int                 DATA_W     = 16,
  parameter logic [DATA_W-1:0]  SUM_TARGET = 16'hBABA,
  parameter logic [DATA_W-1:0]  SIG_MASK   = 16'hC000,
  parameter logic [DATA_W-1:0]  SIG_VALUE  = 16'h4000,
  parameter int                 SIG_INDEX  = 10,
  localparam int                ADDR_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              updateReq,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdDone,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrReq,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memWrDone,
  output logic              busy,
  output logic              imageValid,
  input  logic [ADDR_W-1:0] lookAddr,
  output logic [DATA_W-1:0] lookData
);

  dpStrobe_t strobe;
  logic      atLast;
  logic      atPenult;

  ee_loader_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .updateReq  (updateReq),
    .memRdDone  (memRdDone),
    .memWrDone  (memWrDone),
    .atLast     (atLast),
    .atPenult   (atPenult),
    .strobe     (strobe),
    .memRdReq   (memRdReq),
    .memWrReq   (memWrReq),
    .busy       (busy)
  );

  ee_loader_dp #(
    .WORDS      (WORDS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .SUM_TARGET (SUM_TARGET),
    .SIG_MASK   (SIG_MASK),
    .SIG_VALUE  (SIG_VALUE),
    .SIG_INDEX  (SIG_INDEX)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .memRdData  (memRdData),
    .lookAddr   (lookAddr),
    .memRdAddr  (memRdAddr),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData),
    .atLast     (atLast),
    .atPenult   (atPenult),
    .imageValid (imageValid),
    .lookData   (lookData)
  );

  // R5
  valid_low_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !imageValid);

  // R2
  rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |=> $stable(memRdAddr));

  // R7
  wr_addr_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |-> (memWrAddr == ADDR_W'(WORDS - 1)));

endmodule

// File: tb/tb_ee_image_loader.sv
module tb_ee_image_loader;

  localparam int WORDS  = 64;
  localparam int AW     = 6;
  localparam int LAT    = 3;
  localparam logic [15:0] TARGET = 16'hBABA;

  logic clk = 1'b0;
  logic rstN, startPulse, updateReq;
  logic memRdReq, memRdDone, memWrReq, memWrDone, busy, imageValid;
  logic [AW-1:0] memRdAddr, memWrAddr, lookAddr;
  logic [15:0] memRdData, memWrData, lookData;

  always #5 clk = ~clk;

  ee_image_loader dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .updateReq(updateReq),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdDone(memRdDone),
    .memRdData(memRdData), .memWrReq(memWrReq), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrDone(memWrDone), .busy(busy),
    .imageValid(imageValid), .lookAddr(lookAddr), .lookData(lookData)
  );

  int checks = 0;
  int fails  = 0;

  // EEPROM model, reacting on the falling edge
  logic [15:0] mem [WORDS];
  int  rdCount, wrCount, overlap, lastWrAddr;
  int  addrLog [256];
  bit  rdPend, wrPend;
  int  rdWait, wrWait, rdA, wrA;
  logic [15:0] wrD;

  always @(negedge clk) begin
    memRdDone = 1'b0;
    memWrDone = 1'b0;
    if (!rstN) begin
      rdPend = 0; wrPend = 0;
    end else begin
      if (rdPend) begin
        if (memRdReq) overlap++;
        if (rdWait == 0) begin
          memRdDone = 1'b1; memRdData = mem[rdA]; rdPend = 0;
        end else rdWait--;
      end else if (memRdReq) begin
        rdPend = 1; rdA = int'(memRdAddr); rdWait = LAT;
        if (rdCount < 256) addrLog[rdCount] = rdA;
        rdCount++;
      end
      if (wrPend) begin
        if (memWrReq) overlap++;
        if (wrWait == 0) begin
          memWrDone = 1'b1; mem[wrA] = wrD; wrPend = 0;
        end else wrWait--;
      end else if (memWrReq) begin
        wrPend = 1; wrA = int'(memWrAddr); wrD = memWrData; wrWait = LAT;
        lastWrAddr = wrA; wrCount++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sumFirst(input int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s = s + mem[i];
    return s;
  endfunction

  // fill image; balanced selects a correct last word
  task automatic buildImage(input logic [15:0] seed, input logic [15:0] sigWord, input bit balanced);
    for (int i = 0; i < WORDS; i++) mem[i] = 16'(seed * (i + 7)) ^ 16'(i * 16'h0913);
    mem[10] = sigWord;
    mem[WORDS-1] = TARGET - sumFirst(WORDS - 1) + (balanced ? 16'h0 : 16'h0021);
  endtask

  bit sawValidBusy;

  task automatic clearLog();
    rdCount = 0; wrCount = 0; overlap = 0; lastWrAddr = -1; sawValidBusy = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin
      if (imageValid) sawValidBusy = 1;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse(input bit st, input bit up);
    startPulse = st; updateReq = up;
    @(negedge clk);
    startPulse = 0; updateReq = 0;
  endtask

  function automatic bit seqOk(input int base, input int n);
    for (int i = 0; i < n; i++) if (addrLog[base + i] != i) return 0;
    return 1;
  endfunction

  task automatic t_reset();
    buildImage(16'h0003, 16'h4000, 1);
    clearLog();
    rstN = 0;
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 valid in reset", imageValid, 0);
    chk("R1 rdreq in reset", memRdReq, 0);
    chk("R1 wrreq in reset", memWrReq, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 boot pass busy", busy, 1);
    waitIdle();
    chk("R2 boot read count", rdCount, WORDS);
    chk("R2 ascending order", seqOk(0, WORDS), 1);
    chk("R2 no overlap", overlap, 0);
    chk("R3 good image valid", imageValid, 1);
    chk("R5 valid low while busy", sawValidBusy, 0);
    lookAddr = 6'd10; #1;
    chk("R9 lookup word10", lookData, mem[10]);
    lookAddr = 6'd37; #1;
    chk("R9 lookup word37", lookData, mem[37]);
  endtask

  task automatic t_badSum();
    mem[5] = mem[5] + 16'h0100;
    clearLog();
    pulse(1, 0);
    chk("R6 start makes busy", busy, 1);
    waitIdle();
    chk("R3 bad sum invalid", imageValid, 0);
    chk("R6 start read count", rdCount, WORDS);
  endtask

  task automatic t_badSig();
    buildImage(16'h1234, 16'h8000, 1);
    clearLog();
    pulse(1, 0);
    waitIdle();
    chk("R4 bad signature invalid", imageValid, 0);
  endtask

  task automatic t_maskNoise();
    buildImage(16'h0F0F, 16'h7ABC, 1);
    clearLog();
    pulse(1, 0);
    waitIdle();
    chk("R4 noise outside mask valid", imageValid, 1);
  endtask

  task automatic t_busyIgnore();
    buildImage(16'h0055, 16'h4001, 1);
    clearLog();
    pulse(1, 0);
    repeat (20) @(negedge clk);
    pulse(1, 0);
    repeat (10) @(negedge clk);
    pulse(0, 1);
    waitIdle();
    chk("R6 reads while busy ignored", rdCount, WORDS);
    chk("R6 update while busy ignored", wrCount, 0);
    chk("R5 valid after pass", imageValid, 1);
  endtask

  task automatic t_update(input logic [15:0] sig, input bit expValid, input string tag);
    logic [15:0] expBal;
    buildImage(16'hA5A7, sig, 0);
    expBal = TARGET - sumFirst(WORDS - 1);
    clearLog();
    pulse(0, 1);
    waitIdle();
    chk({"R7 write count ", tag}, wrCount, 1);
    chk({"R7 write addr ", tag}, lastWrAddr, WORDS - 1);
    chk({"R7 balance word ", tag}, mem[WORDS-1], expBal);
    chk({"R7 partial reads ", tag}, seqOk(0, WORDS - 1), 1);
    chk({"R8 rerun reads ", tag}, rdCount, 2 * WORDS - 1);
    chk({"R8 rerun order ", tag}, seqOk(WORDS - 1, WORDS), 1);
    chk({"R8 valid after update ", tag}, imageValid, expValid);
    lookAddr = 6'(WORDS - 1); #1;
    chk({"R9 lookup balance ", tag}, lookData, expBal);
  endtask

  task automatic t_priority();
    buildImage(16'h3C3D, 16'h4000, 0);
    clearLog();
    pulse(1, 1);
    waitIdle();
    chk("R10 update wins", wrCount, 1);
    chk("R10 valid after update", imageValid, 1);
  endtask

  bit finished = 0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    rstN = 0; startPulse = 0; updateReq = 0; lookAddr = '0;
    memRdDone = 0; memWrDone = 0; memRdData = '0;
    @(negedge clk);
    t_reset();
    t_badSum();
    t_badSig();
    t_maskNoise();
    t_busyIgnore();
    t_update(16'h4000, 1, "goodsig");
    t_update(16'h0000, 0, "badsig");
    t_priority();
    finished = 1;
    summary();
  end

endmodule